// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one channel of a compare-match timer for a peripheral subsystem. A 16-bit up-counter advances on single-cycle enables from a free-running prescaler that divides the peripheral clock by 4, 8, 16 or 64. The counter runs only while a start bit is set. When a count enable arrives while the counter holds the compare value, the counter returns to zero and a sticky match flag is raised. The period is therefore the compare value plus one enables.

Software reaches four 16-bit registers over a simple bus with an address, a write strobe, a read strobe and write and read data. Read data is combinational, so it is valid in the cycle the read strobe is high. The match flag uses a two-step clearing handshake. Software must first read the status register while the flag is 1. A later write of 0 to the flag bit then clears it. An interrupt request follows the flag whenever the external enable is high.

Top module: `cmt_channel`

## Requirements
- R1: Register addresses are 0 for status/control, 1 for the counter, 2 for compare and 3 for start. After reset they read 0x0000, 0x0000, 0xFFFF and 0x0000 respectively.
- R2: In the status/control register, bits 15:8 and 5:2 read 0 and ignore writes. Bit 6 is a spare bit that can be written and read back. Bits 1:0 hold the rate select and can be written and read back. Writing 0xFFFF with the flag clear reads back as 0x0043.
- R3: The counter holds its value while bit 0 of the start register is 0.
- R4: The prescaler is a 6-bit count that starts at 0 on reset release and advances every clock. While started, the counter sees an enable in each cycle where the selected low bits of the prescaler are all ones. Rate select 00 gives every 4 cycles, 01 every 8, 10 every 16 and 11 every 64.
- R5: An enable that arrives while the counter equals the compare value sets the flag (bit 7) and loads the counter with 0 on the same edge.
- R6: Writing 1 to bit 7 has no effect. Writing 0 to bit 7 without a prior read that returned the flag as 1 leaves the flag set.
- R7: Writing 0 to bit 7 after the status register has been read with the flag at 1 clears the flag. Once the flag clears, the read-of-1 arming is dropped, so a later setting of the flag needs a fresh read before it can be cleared.
- R8: If a match and a valid clearing write occur in the same cycle, the flag stays set.
- R9: The interrupt request equals the flag ANDed with the interrupt-enable input.
- R10: A write to the counter or to the compare register loads the written value. A counter write overrides a same-cycle enable and suppresses that cycle's match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or rate select does not show at once. It first appears as a wrong counter value on the next read, and it becomes obvious when the match arrives early or late on the interrupt line, within one compare period. A wrong arming bit is harder to see. It only shows at the ports on the next clearing write, as a flag that clears when it should not (or stays set when it should clear), so the bench issues clearing writes both with and without a prior read. The reference model runs in lock-step and checks the interrupt output on every clock, so a wrong flag is reported in the cycle it goes wrong.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int unsigned DATA_W     = 16;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned PRE_W      = 6;
  localparam int unsigned NUM_RATIOS = 4;
  localparam int unsigned FLAG_BIT   = 7;
  localparam int unsigned SPARE_BIT  = 6;
  localparam int unsigned SEL_W      = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CSR = 2'd0,
    REG_CNT = 2'd1,
    REG_CMP = 2'd2,
    REG_RUN = 2'd3
  } cmt_reg_e;

  // log2 of the division ratio chosen by each rate-select code
  function automatic int unsigned ratio_log2(input int unsigned code);
    case (code)
      0:       ratio_log2 = 2;
      1:       ratio_log2 = 3;
      2:       ratio_log2 = 4;
      default: ratio_log2 = 6;
    endcase
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick
);

  logic [CNT_W-1:0]      pre_q;
  logic [CNT_W-1:0]      pre_d;
  logic [NUM_RATIOS-1:0] wrap;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_wrap
    localparam int unsigned LW = ratio_log2(g);
    assign wrap[g] = &pre_q[LW-1:0];
  end

  assign tick = run & wrap[rate_sel];

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
  import cmt_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp,
  output logic         match
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] cmp_q, cmp_d;
  logic         cnt_en;
  logic         at_top;

  always_comb begin
    at_top = (cnt_q == cmp_q);
    match  = tick & at_top & ~cnt_wr;
    cnt_en = cnt_wr | tick;
    if (cnt_wr) begin
      cnt_d = wdata;
    end else if (at_top) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else if (cmp_wr) begin
      cmp_q <= cmp_d;
    end
  end

  assign cnt = cnt_q;
  assign cmp = cmp_q;

endmodule

// File: rtl/cmt_csr.sv
module cmt_csr
  import cmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic              run_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              match,
  output logic              flag,
  output logic              armed,
  output logic              spare,
  output logic [SEL_W-1:0]  rate_sel,
  output logic              run
);

  logic             flag_q, flag_d;
  logic             armed_q, armed_d;
  logic             flag_clr;
  logic             spare_q;
  logic [SEL_W-1:0] sel_q;
  logic             run_q;

  always_comb begin
    flag_clr = csr_wr & ~wdata[FLAG_BIT] & armed_q & flag_q;
    flag_d   = match | (flag_q & ~flag_clr);
    armed_d  = flag_d & (armed_q | (csr_rd & flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spare_q <= 1'b0;
      sel_q   <= '0;
    end else if (csr_wr) begin
      spare_q <= wdata[SPARE_BIT];
      sel_q   <= wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (run_wr) begin
      run_q <= wdata[0];
    end
  end

  assign flag     = flag_q;
  assign armed    = armed_q;
  assign spare    = spare_q;
  assign rate_sel = sel_q;
  assign run      = run_q;

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_en,
  output logic              irq
);

  logic              sel_csr, sel_cnt, sel_cmp, sel_run;
  logic              tick, match;
  logic              flag, armed, spare, run;
  logic [SEL_W-1:0]  rate_sel;
  logic [DATA_W-1:0] cnt_val, cmp_val;

  always_comb begin
    sel_csr = (bus_addr == REG_CSR);
    sel_cnt = (bus_addr == REG_CNT);
    sel_cmp = (bus_addr == REG_CMP);
    sel_run = (bus_addr == REG_RUN);
  end

  cmt_prescaler #(.CNT_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .rate_sel (rate_sel),
    .tick     (tick)
  );

  cmt_counter #(.W(DATA_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnt_wr (bus_wr & sel_cnt),
    .cmp_wr (bus_wr & sel_cmp),
    .wdata  (bus_wdata),
    .cnt    (cnt_val),
    .cmp    (cmp_val),
    .match  (match)
  );

  cmt_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_wr   (bus_wr & sel_csr),
    .csr_rd   (bus_rd & sel_csr),
    .run_wr   (bus_wr & sel_run),
    .wdata    (bus_wdata),
    .match    (match),
    .flag     (flag),
    .armed    (armed),
    .spare    (spare),
    .rate_sel (rate_sel),
    .run      (run)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CSR: begin
        bus_rdata[FLAG_BIT]    = flag;
        bus_rdata[SPARE_BIT]   = spare;
        bus_rdata[SEL_W-1:0]   = rate_sel;
      end
      REG_CNT: bus_rdata = cnt_val;
      REG_CMP: bus_rdata = cmp_val;
      REG_RUN: bus_rdata[0] = run;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag & irq_en;

endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk
  import cmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_en,
  input logic              irq,
  input logic              tick,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] cmp,
  input logic              flag,
  input logic              armed,
  input logic              run
);

  logic cnt_wr_now, clr_wr_now;
  assign cnt_wr_now = bus_wr && (bus_addr == 2'd1);
  assign clr_wr_now = bus_wr && (bus_addr == 2'd0) && !bus_wdata[FLAG_BIT];

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |-> (bus_rdata[15:8] == 8'd0 && bus_rdata[5:2] == 4'd0)); // R2

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr_now) |=> $stable(cnt)); // R3

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R4

  AST_WRAP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp && !cnt_wr_now) |=> (cnt == '0 && flag)); // R5

  AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp && !cnt_wr_now && clr_wr_now) |=> flag); // R8

  AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag); // R6

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr_now) |=> flag); // R7

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $stable(irq_en)) |-> $rose(flag)); // R9

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_now |=> (cnt == $past(bus_wdata))); // R10

endmodule

bind cmt_channel cmt_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_en    (irq_en),
  .irq       (irq),
  .tick      (tick),
  .cnt       (cnt_val),
  .cmp       (cmp_val),
  .flag      (flag),
  .armed     (armed),
  .run       (run)
);

// File: tb/cmt_channel_test.sv
`timescale 1ns/1ps
module cmt_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq_en = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  cmt_channel uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .irq(irq)
  );

  // behavioural reference state
  int m_pre = 0, m_cnt = 0, m_cmp = 65535, m_sel = 0;
  bit m_flag = 0, m_armed = 0, m_spare = 0, m_run = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int mask_of(input int s);
    case (s)
      0: return 3;
      1: return 7;
      2: return 15;
      default: return 63;
    endcase
  endfunction

  function automatic logic [15:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {8'd0, m_flag, m_spare, 4'd0, m_sel[1:0]};
      2'd1: return m_cnt[15:0];
      2'd2: return m_cmp[15:0];
      default: return {15'd0, m_run};
    endcase
  endfunction

  function automatic bit match_next();
    return m_run && ((m_pre & mask_of(m_sel)) == mask_of(m_sel)) && (m_cnt == m_cmp);
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit tk, mt, cw, clr, fn;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_cmp = 65535; m_sel = 0;
      m_flag = 0; m_armed = 0; m_spare = 0; m_run = 0;
    end else if (!done) begin
      chk({15'd0, irq}, {15'd0, m_flag & irq_en}, "R9 irq per cycle");
      tk  = m_run && ((m_pre & mask_of(m_sel)) == mask_of(m_sel));
      cw  = bus_wr && bus_addr == 2'd1;
      mt  = tk && (m_cnt == m_cmp) && !cw;
      clr = bus_wr && bus_addr == 2'd0 && !bus_wdata[7] && m_armed && m_flag;
      fn  = mt ? 1'b1 : (clr ? 1'b0 : m_flag);
      m_armed = fn && (m_armed || (bus_rd && bus_addr == 2'd0 && m_flag));
      m_flag  = fn;
      if (cw) m_cnt = bus_wdata;
      else if (tk) m_cnt = (m_cnt == m_cmp) ? 0 : m_cnt + 1;
      if (bus_wr && bus_addr == 2'd2) m_cmp = bus_wdata;
      if (bus_wr && bus_addr == 2'd0) begin
        m_spare = bus_wdata[6];
        m_sel   = bus_wdata[1:0];
      end
      if (bus_wr && bus_addr == 2'd3) m_run = bus_wdata[0];
      m_pre = (m_pre + 1) % 64;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(bus_rdata, model_read(a), tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(bus_rdata, e, tag);
    chk(bus_rdata, model_read(a), tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_flag(input string tag);
    int n = 0;
    while (!m_flag && n < 600) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    #1 chk({15'd0, irq}, 16'd1, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_exp(2'd0, 16'h0000, "R1 csr reset");
    rd_exp(2'd1, 16'h0000, "R1 counter reset");
    rd_exp(2'd2, 16'hFFFF, "R1 compare reset");
    rd_exp(2'd3, 16'h0000, "R1 start reset");

    // R2 reserved and writable bits
    wr(2'd0, 16'hFFFF);
    rd_exp(2'd0, 16'h0043, "R2 csr mask");
    wr(2'd0, 16'h0000);
    rd_exp(2'd0, 16'h0000, "R2 csr cleared");

    // R3 stopped counter holds
    repeat (20) @(negedge clk);
    rd_exp(2'd1, 16'h0000, "R3 stopped");

    // R4 each rate select
    for (int s = 0; s < 4; s++) begin
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'(s));
      wr(2'd3, 16'h0001);
      repeat (130) @(negedge clk);
      wr(2'd3, 16'h0000);
      rd(2'd1, "R4 counter rate");
    end

    // R10 direct loads
    wr(2'd1, 16'h1234);
    rd_exp(2'd1, 16'h1234, "R10 counter load");
    wr(2'd2, 16'h0005);
    rd_exp(2'd2, 16'h0005, "R10 compare load");

    // R5 match wraps and sets flag
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h0000);
    irq_en = 1'b1;
    wr(2'd3, 16'h0001);
    wait_flag("R5 match seen on irq");
    wr(2'd3, 16'h0000);
    rd(2'd1, "R5 counter after wrap");

    // R6 writes that must not clear
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0080);
    rd_exp(2'd0, 16'h0080, "R6 flag kept");

    // R7 armed clear, then arming dropped
    wr(2'd0, 16'h0000);
    rd_exp(2'd0, 16'h0000, "R7 cleared after read");
    wr(2'd3, 16'h0001);
    wait_flag("R7 flag set again");
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0000);
    rd_exp(2'd0, 16'h0080, "R7 stale arming ignored");
    wr(2'd0, 16'h0000);
    rd_exp(2'd0, 16'h0000, "R7 second clear");

    // R8 match and clear in the same cycle
    wr(2'd3, 16'h0001);
    wait_flag("R8 flag set");
    rd(2'd0, "R8 arming read");
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (match_next()) begin
        bus_addr = 2'd0; bus_wdata = 16'h0000; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        break;
      end
    end
    wr(2'd3, 16'h0000);
    rd_exp(2'd0, 16'h0080, "R8 match wins over clear");

    // R9 interrupt gating
    @(negedge clk);
    irq_en = 1'b0;
    #1 chk({15'd0, irq}, 16'd0, "R9 masked");
    @(negedge clk);
    irq_en = 1'b1;
    #1 chk({15'd0, irq}, 16'd1, "R9 enabled");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule